// File: doc/BRIEF.md
# Flash Status Register and Write-Protection Guard

This block keeps the protection state of a 1 MB serial flash core and judges every array-modifying request against it. It holds a two-bit protection level, a lock flag and a bit that mirrors whether the core is in auto-increment programming mode. All of these are presented together as one status byte. A status-write request loads new protection and lock values. The write is refused when the write-protect pin, after synchronization, is low and the lock flag is set.

For each program, sector-erase or chip-erase request, the block returns a registered verdict one clock later. The verdict says whether the operation may proceed. The protection level selects one of four regions of the 20-bit address space: nothing, the top quarter, the top half, or the whole array. A chip erase is only granted when no region is protected. The command decoder and the array itself sit outside this block. The decoder drives the request strobes and uses the verdict to gate the real operation.

Top module: `flash_wp_guard`

## Requirements
- R1: After synchronous reset the status byte reads 8'h0C: the protection level is 2'b11, the lock flag is 0 and the auto-increment bit is 0. The verdict-valid output is 0.
- R2: The verdict for a request appears on `op_valid`/`op_allow` in the clock cycle after `op_req` is sampled high. `op_valid` is 0 in any cycle that does not follow a request.
- R3: With protection level 2'b00, a program request (`op_kind` 2'b00) and a sector-erase request (2'b01) are allowed at every address. The reserved code 2'b11 is always denied.
- R4: With level 2'b01, a program or sector erase is denied for addresses 20'hC0000 to 20'hFFFFF and allowed below 20'hC0000.
- R5: With level 2'b10, a program or sector erase is denied for addresses 20'h80000 to 20'hFFFFF and allowed below 20'h80000.
- R6: With level 2'b11, every program, sector-erase and chip-erase request is denied.
- R7: A chip erase (`op_kind` 2'b10) is allowed only when the protection level is 2'b00, whatever its address.
- R8: A status write accepted by the lock rule copies data bit 7 into the lock flag and data bits 3:2 into the protection level. Data bits 6:4 and 1:0 are ignored. The status byte places the lock flag at bit 7, the auto-increment bit at bit 6 and the level at bits 3:2; bits 5:4 and 1:0 read 0.
- R9: A status write is discarded, leaving the lock flag and level unchanged, exactly when the synchronized write-protect level is low and the lock flag is 1. With the pin high, or the lock flag 0, the write is applied.
- R10: `wp_n` passes through two flip-flops. A status write sampled at the first or second rising edge after `wp_n` changes is judged with the old pin level. One sampled at the third edge is judged with the new level.
- R11: Status bit 6 shows the value of `aai_mode` sampled at the previous rising edge.
- R12: A request is judged against the protection level held before the edge at which it is sampled. A status write sampled at the same edge affects only later requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrsr_req | input | 1 | Status-write strobe, one cycle per request |
| wrsr_data | input | 8 | Byte carried by the status write |
| wp_n | input | 1 | Asynchronous write-protect pin, active low |
| aai_mode | input | 1 | High while the core is in auto-increment programming mode |
| op_req | input | 1 | Operation request strobe |
| op_kind | input | 2 | 00 program, 01 sector erase, 10 chip erase, 11 reserved |
| op_addr | input | 20 | Byte address of the operation |
| status_byte | output | 8 | Current status byte |
| op_valid | output | 1 | Verdict for the previous cycle's request is present |
| op_allow | output | 1 | Verdict: 1 allow, 0 deny |

## Verification
The bench probes the exact region edges, 20'hBFFFF/20'hC0000 and 20'h7FFFF/20'h80000. A comparator written one address off, or testing the wrong bit, would grant a write to the first protected byte or deny the last free one. It sets the lock while the pin is high, then drops the pin and writes again. A design that ignored the pin would stay frozen after the pin rises again. A design that ignored the lock would accept the locked write. It toggles the pin together with a status write and counts edges. This catches a synchronizer with the wrong depth, or a lock decision taken from the raw pin. It also issues a request and a status write at the same edge, so a verdict built on the freshly written level is caught.

// File: rtl/flash_wp_pkg.sv
`timescale 1ns/1ps
package flash_wp_pkg;

    parameter int ADDR_W = 20;

    localparam int BPL_POS = 7;
    localparam int AAI_POS = 6;
    localparam int LVL_HI  = 3;
    localparam int LVL_LO  = 2;

    typedef enum logic [1:0] {
        OP_PROG = 2'b00,
        OP_SECT = 2'b01,
        OP_CHIP = 2'b10,
        OP_RSVD = 2'b11
    } op_kind_e;

    typedef struct packed {
        logic       lock;
        logic       aai;
        logic [1:0] lvl;
    } guard_state_t;

    localparam guard_state_t STATE_RESET = '{lock: 1'b0, aai: 1'b0, lvl: 2'b11};

    function automatic logic [7:0] pack_status(guard_state_t s);
        logic [7:0] b;
        b = 8'h00;
        b[BPL_POS] = s.lock;
        b[AAI_POS] = s.aai;
        b[LVL_HI:LVL_LO] = s.lvl;
        return b;
    endfunction

    // top2 holds the two most significant address bits
    function automatic logic in_region(logic [1:0] lvl, logic [1:0] top2);
        case (lvl)
            2'b00:   return 1'b0;
            2'b01:   return top2 == 2'b11;
            2'b10:   return top2[1];
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/wp_sync.sv
`timescale 1ns/1ps
module wp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic level
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= pin_n;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], pin_n};
            end
        end
    endgenerate

    assign level = chain[STAGES-1];
endmodule

// File: rtl/status_reg.sv
`timescale 1ns/1ps
module status_reg
    import flash_wp_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         wrsr_req,
    input  logic [7:0]   wrsr_data,
    input  logic         wp_level,
    input  logic         aai_mode,
    output guard_state_t st
);
    logic frozen;
    logic unused_data;

    assign frozen      = !wp_level && st.lock;
    assign unused_data = ^{wrsr_data[6:4], wrsr_data[1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= STATE_RESET;
        end else begin
            st.aai <= aai_mode;
            if (wrsr_req && !frozen) begin
                st.lock <= wrsr_data[BPL_POS];
                st.lvl  <= wrsr_data[LVL_HI:LVL_LO];
            end
        end
    end

    p_write_r8: assert property (@(posedge clk) disable iff (rst)
        (wrsr_req && wp_level) |=> (st.lvl == $past(wrsr_data[3:2]) && st.lock == $past(wrsr_data[7])));

    p_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        (wrsr_req && !wp_level && st.lock) |=> $stable({st.lock, st.lvl}));

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !wrsr_req |=> $stable({st.lock, st.lvl}));

    p_aai_set_r11: assert property (@(posedge clk) disable iff (rst)
        aai_mode |=> st.aai);

    p_aai_clr_r11: assert property (@(posedge clk) disable iff (rst)
        !aai_mode |=> !st.aai);
endmodule

// File: rtl/region_check.sv
`timescale 1ns/1ps
module region_check
    import flash_wp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       op_req,
    input  op_kind_e   op_kind,
    input  logic [1:0] addr_top,
    input  logic [1:0] lvl,
    output logic       op_valid,
    output logic       op_allow
);
    logic grant;

    always_comb begin
        case (op_kind)
            OP_PROG, OP_SECT: grant = !in_region(lvl, addr_top);
            OP_CHIP:          grant = (lvl == 2'b00);
            default:          grant = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op_valid <= 1'b0;
            op_allow <= 1'b0;
        end else begin
            op_valid <= op_req;
            op_allow <= op_req && grant;
        end
    end

    p_valid_r2: assert property (@(posedge clk) disable iff (rst)
        op_req |=> op_valid);

    p_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !op_req |=> !op_valid);

    p_full_r6: assert property (@(posedge clk) disable iff (rst)
        (op_req && lvl == 2'b11) |=> !op_allow);

    p_chip_r7: assert property (@(posedge clk) disable iff (rst)
        (op_req && op_kind == OP_CHIP && lvl != 2'b00) |=> !op_allow);

    p_free_r3: assert property (@(posedge clk) disable iff (rst)
        (op_req && lvl == 2'b00 && op_kind != OP_RSVD) |=> op_allow);
endmodule

// File: rtl/flash_wp_guard.sv
`timescale 1ns/1ps
module flash_wp_guard
    import flash_wp_pkg::*;
#(
    parameter int AW        = flash_wp_pkg::ADDR_W,
    parameter int WP_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wrsr_req,
    input  logic [7:0]    wrsr_data,
    input  logic          wp_n,
    input  logic          aai_mode,
    input  logic          op_req,
    input  logic [1:0]    op_kind,
    input  logic [AW-1:0] op_addr,
    output logic [7:0]    status_byte,
    output logic          op_valid,
    output logic          op_allow
);
    localparam int TOP_LO = AW - 2;

    logic         wp_level;
    guard_state_t st;
    logic         unused_addr;

    assign unused_addr = ^op_addr[TOP_LO-1:0];

    wp_sync #(.STAGES(WP_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .pin_n (wp_n),
        .level (wp_level)
    );

    status_reg u_status (
        .clk       (clk),
        .rst       (rst),
        .wrsr_req  (wrsr_req),
        .wrsr_data (wrsr_data),
        .wp_level  (wp_level),
        .aai_mode  (aai_mode),
        .st        (st)
    );

    region_check u_region (
        .clk      (clk),
        .rst      (rst),
        .op_req   (op_req),
        .op_kind  (op_kind_e'(op_kind)),
        .addr_top (op_addr[AW-1:TOP_LO]),
        .lvl      (st.lvl),
        .op_valid (op_valid),
        .op_allow (op_allow)
    );

    assign status_byte = pack_status(st);

    p_status_pad_r8: assert property (@(posedge clk) disable iff (rst)
        (status_byte[5:4] == 2'b00) && (status_byte[1:0] == 2'b00));
endmodule

// File: tb/test_flash_wp_guard.sv
`timescale 1ns/1ps
module test_flash_wp_guard;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wrsr_req = 1'b0;
    logic [7:0]  wrsr_data = 8'h00;
    logic        wp_n = 1'b1;
    logic        aai_mode = 1'b0;
    logic        op_req = 1'b0;
    logic [1:0]  op_kind = 2'b00;
    logic [19:0] op_addr = 20'h0;
    logic [7:0]  status_byte;
    logic        op_valid;
    logic        op_allow;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    flash_wp_guard i_flash_wp_guard (
        .clk(clk), .rst(rst), .wrsr_req(wrsr_req), .wrsr_data(wrsr_data),
        .wp_n(wp_n), .aai_mode(aai_mode), .op_req(op_req), .op_kind(op_kind),
        .op_addr(op_addr), .status_byte(status_byte), .op_valid(op_valid),
        .op_allow(op_allow)
    );

    // behavioural reference model
    int m_lvl, m_lock, m_aai, m_valid, m_allow;
    int wpq[$];

    function automatic int judge(int lvl, int kind, int addr);
        int first_prot;
        if (kind == 3) return 0;
        if (kind == 2) return (lvl == 0) ? 1 : 0;
        if (lvl == 0) return 1;
        first_prot = (lvl == 1) ? 'hC0000 : (lvl == 2) ? 'h80000 : 0;
        return (addr >= first_prot) ? 0 : 1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_lvl = 3; m_lock = 0; m_aai = 0; m_valid = 0; m_allow = 0;
            wpq = {1, 1};
        end else begin
            int seen_wp;
            seen_wp = wpq[0];
            void'(wpq.pop_front());
            wpq.push_back(int'(wp_n));
            m_valid = int'(op_req);
            m_allow = op_req ? judge(m_lvl, int'(op_kind), int'(op_addr)) : 0;
            if (wrsr_req && (seen_wp == 1 || m_lock == 0)) begin
                m_lock = int'(wrsr_data[7]);
                m_lvl  = int'(wrsr_data[3:2]);
            end
            m_aai = int'(aai_mode);
        end
    end

    task automatic chk(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            chk("R8 R9 R11 model status", int'(status_byte),
                (m_lock << 7) | (m_aai << 6) | (m_lvl << 2));
            chk("R2 model valid", int'(op_valid), m_valid);
            chk("R3 R4 R5 R6 R7 model verdict", int'(op_allow), m_allow);
        end
    end

    task automatic wrsr(logic [7:0] d);
        wrsr_req = 1'b1; wrsr_data = d;
        @(negedge clk);
        wrsr_req = 1'b0;
    endtask

    task automatic op(string tag, logic [1:0] k, logic [19:0] a, int exp);
        op_req = 1'b1; op_kind = k; op_addr = a;
        @(negedge clk);
        op_req = 1'b0;
        chk({tag, " valid"}, int'(op_valid), 1);
        chk(tag, int'(op_allow), exp);
    endtask

    task automatic set_wp(logic v);
        wp_n = v;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 status", int'(status_byte), 'h0C);
        chk("R1 valid", int'(op_valid), 0);

        op("R6 prog 0", 2'b00, 20'h00000, 0);
        op("R6 sect 7FFFF", 2'b01, 20'h7FFFF, 0);
        op("R6 chip", 2'b10, 20'h00000, 0);

        wrsr(8'h00);
        chk("R8 clear level", int'(status_byte), 'h00);
        op("R3 prog FFFFF", 2'b00, 20'hFFFFF, 1);
        @(negedge clk);
        chk("R2 valid drops", int'(op_valid), 0);
        op("R3 sect 0", 2'b01, 20'h00000, 1);
        op("R3 reserved", 2'b11, 20'h00000, 0);
        op("R7 chip free", 2'b10, 20'hABCDE, 1);

        wrsr(8'h77);
        chk("R8 ignored bits", int'(status_byte), 'h04);
        op("R4 prog BFFFF", 2'b00, 20'hBFFFF, 1);
        op("R4 prog C0000", 2'b00, 20'hC0000, 0);
        op("R4 sect FFFFF", 2'b01, 20'hFFFFF, 0);
        op("R7 chip quarter", 2'b10, 20'h00000, 0);

        wrsr(8'h08);
        chk("R8 half", int'(status_byte), 'h08);
        op("R5 prog 7FFFF", 2'b00, 20'h7FFFF, 1);
        op("R5 sect 80000", 2'b01, 20'h80000, 0);
        op("R7 chip half", 2'b10, 20'h00000, 0);

        wrsr(8'h80);
        chk("R8 lock set", int'(status_byte), 'h80);
        set_wp(1'b0);
        wrsr(8'h0C);
        chk("R9 locked write", int'(status_byte), 'h80);
        op("R9 chip still free", 2'b10, 20'h00000, 1);
        set_wp(1'b1);
        wrsr(8'h0C);
        chk("R9 pin high", int'(status_byte), 'h0C);
        set_wp(1'b0);
        wrsr(8'h08);
        chk("R9 lock clear pin low", int'(status_byte), 'h08);
        wrsr(8'h80);
        chk("R9 relock", int'(status_byte), 'h80);

        // R10: pin rises together with a write
        wp_n = 1'b1; wrsr_req = 1'b1; wrsr_data = 8'h04;
        @(negedge clk);
        chk("R10 first edge", int'(status_byte), 'h80);
        @(negedge clk);
        chk("R10 second edge", int'(status_byte), 'h80);
        @(negedge clk);
        wrsr_req = 1'b0;
        chk("R10 third edge", int'(status_byte), 'h04);

        aai_mode = 1'b1;
        @(negedge clk);
        chk("R11 aai on", int'(status_byte), 'h44);
        aai_mode = 1'b0;
        @(negedge clk);
        chk("R11 aai off", int'(status_byte), 'h04);

        // R12: write and request at one edge
        wrsr_req = 1'b1; wrsr_data = 8'h00;
        op("R12 old level", 2'b00, 20'hFFFFF, 0);
        wrsr_req = 1'b0;
        chk("R12 status", int'(status_byte), 'h00);
        op("R12 new level", 2'b00, 20'hFFFFF, 1);

        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule